// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo PCM bit stream into parallel samples. Three serial inputs arrive from an external audio source: a bit clock, a word clock and a data line. All three are oversampled by the much faster system clock through two-flop synchronizers. The edges of the bit clock are found by comparing successive synchronized values. Each completed stereo pair is presented as a left sample and a right sample, together with a strobe that is high for one system cycle.

A two-bit format input selects one of four framing conventions, and a width input selects 16-bit or 18-bit words. The four conventions are:
- Delayed (I2S-style): the MSB follows each word-clock edge by one bit period.
- Left-aligned: the MSB is in the first bit period after the word-clock edge.
- DSP pulse: a short word-clock pulse announces each word, and data is taken on falling bit-clock edges.
- Packed: each 16-bit word exactly fills its half of a 32-bit-clock frame.

Format and width are taken up only while no word is in progress, or when a stereo pair completes. A change made at a pair boundary discards the partial frame, so decoding restarts cleanly.

Top module: `audio_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first pair completes, `left_o` and `right_o` read zero and `valid_o` is low.
- R2: Format code 0 (delayed): word clock low marks the left word and high marks the right word. Data is taken on rising bit-clock edges. The MSB is the bit taken at the second rising edge after a word-clock change.
- R3: Format code 1 (left-aligned): word clock high marks the left word and low marks the right word. Data is taken on rising edges. The MSB is the bit taken at the first rising edge after a word-clock change.
- R4: Format code 2 (DSP pulse): data is taken on falling bit-clock edges. A word closes when the word clock is first seen high. The next word starts with its MSB at the first falling edge where the word clock is seen low again.
- R5: In format 2, the first word after reset is the left word, and later words alternate right, left, right, and so on.
- R6: The word length is 18 when `w18_i` is 1 and the format is not 3, and 16 otherwise. Format 3 (packed) is left-aligned with exactly 16 bit periods per half-frame. A sample occupies bits [L-1:0] of its output, with the MSB first on the wire, and the bits above it read zero.
- R7: Bits received past the word length before the word closes are ignored. If a word closes after fewer bits than the word length, its unfilled low bits read zero.
- R8: `valid_o` is high for exactly one cycle each time a right word closes after a left word was stored. `left_o` and `right_o` change only in that cycle, and both change together.
- R9: Data received before the first recognised word start after reset is discarded. A right word that closes with no stored left word produces no output.
- R10: A change of `fmt_i` or `w18_i` while a word is in progress does not alter the pair being received. The change is applied when that pair completes, and the receiver then restarts framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Word clock or sync pulse (asynchronous) |
| sdat_i | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_i | input | 2 | Framing: 0 delayed, 1 left-aligned, 2 DSP pulse, 3 packed |
| w18_i | input | 1 | 1 selects 18-bit words (ignored in packed format) |
| left_o | output | 18 | Left sample of the last completed pair |
| right_o | output | 18 | Right sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bound assertions check properties on every cycle:
- the strobe never lasts more than one cycle;
- the outputs never move outside a strobe cycle;
- a strobe only follows a bit-clock sampling edge;
- a 16-bit pair never has bits set above bit 15.

Other behaviours can only be shown by the bench scenarios, because they depend on the serial stream. These are:
- channel polarity and MSB position in each framing;
- left/right alternation in pulse mode;
- truncation of over-long words and zero-fill of short ones;
- dropping of a leading partial word and of an orphan right word;
- the deferral of a width change to the pair boundary.

// File: rtl/arx_pkg.sv
`timescale 1ns/1ps
package arx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSP  = 2'd2,
    FMT_PACK = 2'd3
  } fmt_e;
endpackage

// File: rtl/arx_sync.sv
`timescale 1ns/1ps
module arx_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/arx_edge.sv
`timescale 1ns/1ps
module arx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  input  logic fall_sel,
  output logic samp
);
  logic bclk_d, bclk_d_n;

  assign bclk_d_n = bclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_d_n;
  end

  // Rising edge for most formats, falling edge for the pulse format
  assign samp = fall_sel ? (bclk_d & ~bclk_s) : (bclk_s & ~bclk_d);
endmodule

// File: rtl/arx_frame.sv
`timescale 1ns/1ps
module arx_frame
  import arx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp,
  input  logic       wclk_s,
  input  logic [1:0] fmt_in,
  input  logic       w18_in,
  input  logic       idle,
  input  logic       pair_done,
  output fmt_e       cfg_fmt,
  output logic       wide,
  output logic       open_s,
  output logic       close_s,
  output logic       open_left,
  output logic       abort
);
  logic       lw, llw, tog, cfg_w18;
  logic [1:0] prime_cnt;
  logic       lw_n, llw_n, tog_n, cfg_w18_n;
  logic [1:0] prime_n;
  fmt_e       cfg_fmt_n;

  logic is_dsp, is_i2s, primed, cur_lvl, prv_lvl, lvl_edge;
  logic dsp_start, dsp_end, cfg_load;

  assign is_dsp = (cfg_fmt == FMT_DSP);
  assign is_i2s = (cfg_fmt == FMT_I2S);
  assign primed = (prime_cnt == 2'd2);

  // Delayed format: use the word clock one sample late, inverted, so it
  // lines up with the left-aligned decode (high = left).
  assign cur_lvl  = is_i2s ? ~lw  : wclk_s;
  assign prv_lvl  = is_i2s ? ~llw : lw;
  assign lvl_edge = primed & (cur_lvl ^ prv_lvl);

  assign dsp_start = primed & lw & ~wclk_s;
  assign dsp_end   = primed & ~lw & wclk_s;

  assign open_s    = samp & (is_dsp ? dsp_start : lvl_edge);
  assign close_s   = samp & (is_dsp ? dsp_end   : lvl_edge);
  assign open_left = is_dsp ? ~tog : cur_lvl;

  assign cfg_load = idle | pair_done;
  assign abort    = cfg_load & ((fmt_e'(fmt_in) != cfg_fmt) | (w18_in != cfg_w18));
  assign wide     = cfg_w18 & (cfg_fmt != FMT_PACK);

  always_comb begin
    lw_n      = lw;
    llw_n     = llw;
    prime_n   = prime_cnt;
    tog_n     = tog;
    cfg_fmt_n = cfg_fmt;
    cfg_w18_n = cfg_w18;
    if (samp) begin
      lw_n  = wclk_s;
      llw_n = lw;
      if (!primed) prime_n = prime_cnt + 2'd1;
    end
    if (open_s && is_dsp) tog_n = ~tog;
    if (abort)            tog_n = 1'b0;
    if (cfg_load) begin
      cfg_fmt_n = fmt_e'(fmt_in);
      cfg_w18_n = w18_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lw        <= 1'b0;
      llw       <= 1'b0;
      prime_cnt <= 2'd0;
      tog       <= 1'b0;
      cfg_fmt   <= FMT_I2S;
      cfg_w18   <= 1'b0;
    end else begin
      lw        <= lw_n;
      llw       <= llw_n;
      prime_cnt <= prime_n;
      tog       <= tog_n;
      cfg_fmt   <= cfg_fmt_n;
      cfg_w18   <= cfg_w18_n;
    end
  end
endmodule

// File: rtl/arx_cap.sv
`timescale 1ns/1ps
module arx_cap #(
  parameter int WMAX = 18,
  parameter int WMIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp,
  input  logic            sdat_s,
  input  logic            open_s,
  input  logic            close_s,
  input  logic            open_left,
  input  logic            wide,
  input  logic            abort,
  output logic [WMAX-1:0] left_o,
  output logic [WMAX-1:0] right_o,
  output logic            valid_o,
  output logic            idle,
  output logic            pair_done
);
  localparam int CW = $clog2(WMAX + 1);

  logic [WMAX-1:0] word, hold_l, lo, ro;
  logic [CW-1:0]   cnt;
  logic            in_word, cur_left, have_l, vo;

  logic [WMAX-1:0] word_n, hold_n, lo_n, ro_n;
  logic [CW-1:0]   cnt_n, wlen, top_idx, bit_idx;
  logic            in_n, cl_n, have_n, vo_n, left_done;

  assign wlen      = wide ? CW'(WMAX) : CW'(WMIN);
  assign top_idx   = wlen - CW'(1);
  assign bit_idx   = wlen - CW'(1) - cnt;
  assign left_done = close_s & in_word & cur_left;
  assign pair_done = close_s & in_word & ~cur_left & have_l;
  assign idle      = ~in_word & ~have_l;

  always_comb begin
    word_n = word;
    cnt_n  = cnt;
    in_n   = in_word;
    cl_n   = cur_left;
    hold_n = hold_l;
    have_n = have_l;
    lo_n   = lo;
    ro_n   = ro;
    vo_n   = 1'b0;
    if (left_done) begin
      hold_n = word;
      have_n = 1'b1;
    end
    if (pair_done) begin
      lo_n   = hold_l;
      ro_n   = word;
      vo_n   = 1'b1;
      have_n = 1'b0;
    end
    if (close_s) in_n = 1'b0;
    if (open_s) begin
      word_n          = '0;
      word_n[top_idx] = sdat_s;
      cnt_n           = CW'(1);
      in_n            = 1'b1;
      cl_n            = open_left;
    end else if (samp && in_word && !close_s && (cnt < wlen)) begin
      word_n[bit_idx] = sdat_s;
      cnt_n           = cnt + CW'(1);
    end
    if (abort) begin
      in_n   = 1'b0;
      have_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word     <= '0;
      cnt      <= '0;
      in_word  <= 1'b0;
      cur_left <= 1'b0;
      hold_l   <= '0;
      have_l   <= 1'b0;
      lo       <= '0;
      ro       <= '0;
      vo       <= 1'b0;
    end else begin
      word     <= word_n;
      cnt      <= cnt_n;
      in_word  <= in_n;
      cur_left <= cl_n;
      hold_l   <= hold_n;
      have_l   <= have_n;
      lo       <= lo_n;
      ro       <= ro_n;
      vo       <= vo_n;
    end
  end

  assign left_o  = lo;
  assign right_o = ro;
  assign valid_o = vo;
endmodule

// File: rtl/audio_rx.sv
`timescale 1ns/1ps
module audio_rx
  import arx_pkg::*;
#(
  parameter int WMAX = 18,
  parameter int WMIN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_i,
  input  logic            wclk_i,
  input  logic            sdat_i,
  input  logic [1:0]      fmt_i,
  input  logic            w18_i,
  output logic [WMAX-1:0] left_o,
  output logic [WMAX-1:0] right_o,
  output logic            valid_o
);
  logic       rst_q;
  logic [2:0] s_in;
  logic       samp, wide, open_s, close_s, open_left, abort, idle, pair_done;
  fmt_e       cfg_fmt;

  arx_sync #(.N(1)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  arx_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({bclk_i, wclk_i, sdat_i}), .q(s_in)
  );

  arx_edge u_edge (
    .clk(clk), .rst_n(rst_q), .bclk_s(s_in[2]),
    .fall_sel(cfg_fmt == FMT_DSP), .samp(samp)
  );

  arx_frame u_frame (
    .clk(clk), .rst_n(rst_q), .samp(samp), .wclk_s(s_in[1]),
    .fmt_in(fmt_i), .w18_in(w18_i), .idle(idle), .pair_done(pair_done),
    .cfg_fmt(cfg_fmt), .wide(wide), .open_s(open_s), .close_s(close_s),
    .open_left(open_left), .abort(abort)
  );

  arx_cap #(.WMAX(WMAX), .WMIN(WMIN)) u_cap (
    .clk(clk), .rst_n(rst_q), .samp(samp), .sdat_s(s_in[0]),
    .open_s(open_s), .close_s(close_s), .open_left(open_left),
    .wide(wide), .abort(abort), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .idle(idle), .pair_done(pair_done)
  );
endmodule

// File: rtl/arx_chk.sv
`timescale 1ns/1ps
module arx_chk #(
  parameter int WMAX = 18,
  parameter int WMIN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WMAX-1:0] left_o,
  input logic [WMAX-1:0] right_o,
  input logic            valid_o,
  input logic            wide,
  input logic            samp
);
  // R8: the strobe lasts one cycle
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R8: samples move only together with the strobe
  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R8: a pair can only complete on a bit-clock sampling edge
  a_r8_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(samp));

  // R6: a 16-bit pair has nothing above its word length
  a_r6_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !$past(wide)) |->
      (left_o[WMAX-1:WMIN] == '0 && right_o[WMAX-1:WMIN] == '0));
endmodule

bind audio_rx arx_chk #(.WMAX(WMAX), .WMIN(WMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .left_o(left_o), .right_o(right_o),
  .valid_o(valid_o), .wide(wide), .samp(samp)
);

// File: tb/sim_audio_rx.sv
`timescale 1ns/1ps
module sim_audio_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, sdat = 1'b0, w18 = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [17:0] left_o, right_o;
  logic valid_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, fall_mode = 0;
  int mode = 0;
  string cur_tag = "R1";
  logic [17:0] exp_l[$], exp_r[$];

  always #2.5 clk = ~clk;

  audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdat_i(sdat),
    .fmt_i(fmt), .w18_i(w18), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  // Compare every cycle: a strobe must match the model's next pair
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_l.size() == 0) chk("R8 unexpected strobe", 18'h1, 18'h0);
      else begin
        chk({cur_tag, " left"},  left_o,  exp_l.pop_front());
        chk({cur_tag, " right"}, right_o, exp_r.pop_front());
      end
    end
  end

  task automatic bit_out(input logic w, input logic d);
    if (fall_mode) begin
      bclk = 1'b1; wclk = w; sdat = d;
      repeat (4) @(posedge clk); #1;
      bclk = 1'b0;
      repeat (4) @(posedge clk); #1;
    end else begin
      bclk = 1'b0; wclk = w; sdat = d;
      repeat (4) @(posedge clk); #1;
      bclk = 1'b1;
      repeat (4) @(posedge clk); #1;
    end
  endtask

  task automatic send_half(input logic lv, input logic [17:0] v, input int wl,
                           input int slot, input bit flip);
    for (int i = 0; i < slot; i++) begin
      logic wv, dv;
      int k;
      dv = 1'($urandom_range(0, 1));
      wv = lv;
      k = (mode == 1 || mode == 3) ? i : i - 1;
      if (mode == 2) wv = (i == 0);
      if (k >= 0 && k < wl) dv = v[wl-1-k];
      if (flip && i == 3) w18 = ~w18;
      bit_out(wv, dv);
    end
  endtask

  function automatic logic [17:0] expect_w(input logic [17:0] v, input int wl, input int avail);
    logic [17:0] r;
    r = '0;
    for (int i = 0; i < wl; i++) if (i < avail) r[wl-1-i] = v[wl-1-i];
    return r;
  endfunction

  task automatic run(input int m, input logic w, input int slot, input int npair,
                     input string tag, input bit lead_right, input bit flip);
    int wl, avail;
    logic left_lv;
    mode = m; fmt = 2'(m); w18 = w; fall_mode = (m == 2); cur_tag = tag;
    wl = (w && m != 3) ? 18 : 16;
    avail = (m == 1 || m == 3) ? slot : slot - 1;
    left_lv = (m == 0) ? 1'b0 : 1'b1;
    rst_n = 1'b0;
    bclk = fall_mode; wclk = (m == 2) ? 1'b0 : ~left_lv; sdat = 1'b0;
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    chk("R1 left during reset", left_o, 18'h0);
    chk("R1 valid during reset", {17'h0, valid_o}, 18'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    @(negedge clk);
    chk("R1 right after reset", right_o, 18'h0);
    @(posedge clk); #1;
    // Prelude: no recognised word start yet (R9)
    for (int i = 0; i < 4; i++)
      bit_out((m == 2) ? 1'b0 : (lead_right ? left_lv : ~left_lv), 1'($urandom_range(0, 1)));
    if (lead_right) send_half(~left_lv, 18'h3ffff, wl, slot, 1'b0);
    for (int p = 0; p < npair; p++) begin
      logic [17:0] l, r;
      l = 18'($urandom) & 18'((1 << wl) - 1);
      r = 18'($urandom) & 18'((1 << wl) - 1);
      send_half(left_lv, l, wl, slot, flip && (p == npair - 1));
      send_half(~left_lv, r, wl, slot, 1'b0);
      exp_l.push_back(expect_w(l, wl, avail));
      exp_r.push_back(expect_w(r, wl, avail));
    end
    send_half(left_lv, 18'h0, wl, 4, 1'b0);
    repeat (16) @(posedge clk); #1;
    chk({tag, " R8 R9 pending pairs"}, 18'(exp_l.size()), 18'h0);
    exp_l.delete(); exp_r.delete();
  endtask

  initial begin
    run(0, 1'b0, 32, 3, "R2 R7 delayed 16", 1'b0, 1'b0);
    run(0, 1'b1, 24, 3, "R2 delayed 18", 1'b0, 1'b0);
    run(1, 1'b0, 20, 3, "R3 left-aligned 16", 1'b0, 1'b0);
    run(1, 1'b1, 18, 3, "R3 left-aligned 18", 1'b0, 1'b0);
    run(2, 1'b0, 20, 3, "R4 R5 pulse 16", 1'b0, 1'b0);
    run(2, 1'b1, 24, 4, "R4 R5 pulse 18", 1'b0, 1'b0);
    run(3, 1'b1, 16, 3, "R6 packed", 1'b0, 1'b0);
    run(1, 1'b1, 12, 2, "R7 short words", 1'b0, 1'b0);
    run(1, 1'b0, 24, 2, "R9 orphan right", 1'b1, 1'b0);
    run(1, 1'b0, 20, 2, "R10 width change", 1'b0, 1'b1);
    done = 1;
    finish_run();
  end
endmodule